// File: doc/BRIEF.md
# Peripheral Module Stop Controller

This block decides which peripheral modules on a chip receive a clock. A bank of modules is split into 32-bit words. Software writes a control word to request that modules stop (bit set) or run (bit clear). The block turns each control bit into a per-module clock-enable. The modules return a stop-acknowledge. The block brings each acknowledge into its own clock domain through a chain of flops and shows it in a read-only status word, where 1 means stopped and 0 means running.

A module with index `i` is served by word `i / 32`, bit `i % 32`, in both the control and the status space. Software enables a module with a read-modify-write of its control word. It then polls the status bit until it reads 0. The module counts as running only at that point. The poll limit and the timeout handling belong to software. The flops that actually gate the clocks sit outside this block.

Top module: `modstop_ctrl`

## Requirements
- R1: Module index `i` maps to control and status word `i / 32` and bit `i % 32`, and drives `mod_clk_en[i]`.
- R2: One cycle after a control write, `mod_clk_en` for each module of that word equals the inverse of the written bit: a written 1 stops the module and a written 0 lets it run.
- R3: While `rst_n` is low at a clock edge, every control bit becomes 1 and every status bit becomes 1. After reset, `mod_clk_en` is all zero and every control and status word reads `0xFFFFFFFF`.
- R4: A control write replaces only the addressed word. Every other control word keeps its value, and a read returns the last value written.
- R5: A status bit equals the module's `mod_stop_ack` bit as it was SYNC_STAGES clock edges earlier (default 2). Status therefore reflects a control change only after the module has acknowledged it.
- R6: Status words are read-only. A write to a status address leaves all control words, all enables and all status words unchanged.
- R7: A read from an address that is not a control or status word returns 0, and a write to such an address has no effect. Addresses that are not word-aligned count as unmapped.
- R8: Control word `b` sits at byte address CTRL_BASE + 4*b (default 0x130). Status word `b` sits at STAT_BASE + 4*b (default 0x030). There are NUM_BANKS words of each kind (default 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (12) | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mod_clk_en | output | NUM_BANKS*32 | Per-module clock enable, 1 = clock running |
| mod_stop_ack | input | NUM_BANKS*32 | Per-module stop acknowledge, 1 = module stopped |

## Verification
The bench times the status bit after a module is released and counts the exact number of polls that still read "stopped". A design that bypassed the acknowledge, or used the wrong number of synchronizer stages, would clear early or late. It writes one word and reads back every other word, which catches decode faults that spill a write into a neighbouring bank. It also writes to status addresses, to the first address past each range and to misaligned addresses, which catches a design that stores such writes or returns stale data for them. Random traffic across all three address classes is compared with a word-level model.

// File: rtl/modstop_pkg.sv
// Package: shared constants and types for the module stop controller.
// Assumes 32 modules per control/status word.
package modstop_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CTRL = 2'd1,
        ACC_STAT = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/modstop_decode.sv
// Address decoder: classifies a byte address as a control word, a status
// word or unmapped, and returns the bank number.
// Assumes the two ranges do not overlap and that only word-aligned
// addresses can hit.
module modstop_decode
    import modstop_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_BANKS = 12,
    parameter int unsigned CTRL_BASE = 'h130,
    parameter int unsigned STAT_BASE = 'h030,
    parameter int          BANK_W    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [BANK_W-1:0] bank
);
    // Compare the address with every word address of both ranges.
    always_comb begin
        kind = ACC_NONE;
        bank = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(CTRL_BASE + 4 * b)) begin
                kind = ACC_CTRL;
                bank = BANK_W'(b);
            end
            if (addr == ADDR_W'(STAT_BASE + 4 * b)) begin
                kind = ACC_STAT;
                bank = BANK_W'(b);
            end
        end
    end
endmodule

// File: rtl/modstop_ctrl_word.sv
// One control word: holds the stop request bits of up to 32 modules.
// Assumes that a write replaces the whole word (software does the
// read-modify-write). Resets to all ones, so every module starts stopped.
module modstop_ctrl_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] word_q
);
    // Hold the stop requests and load new ones on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '1;
        else if (wr_en)
            word_q <= wr_data;
    end
endmodule

// File: rtl/modstop_status_sync.sv
// Stop-acknowledge synchronizer: a chain of STAGES flops per bit that sets
// the delay from an acknowledge change to its appearance in status.
// Assumes STAGES >= 1. Resets to all ones (every module reads stopped).
module modstop_status_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ack_in,
    output logic [W-1:0] status_q
);
    logic [W-1:0] stg [STAGES];

    // Shift the acknowledges along the chain once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++)
                stg[s] <= '1;
        end else begin
            stg[0] <= ack_in;
            for (int s = 1; s < STAGES; s++)
                stg[s] <= stg[s-1];
        end
    end

    assign status_q = stg[STAGES-1];
endmodule

// File: rtl/modstop_ctrl.sv
// Module stop controller, top level. Holds NUM_BANKS control words that
// request modules to stop, drives the per-module clock enables from them,
// and shows the synchronized stop acknowledges in read-only status words.
// Assumes a single clock and a register port with a one-cycle write strobe.
// Reads are combinational.
module modstop_ctrl
    import modstop_pkg::*;
#(
    parameter int          NUM_BANKS   = 12,
    parameter int          ADDR_W      = 12,
    parameter int unsigned CTRL_BASE   = 'h130,
    parameter int unsigned STAT_BASE   = 'h030,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [WORD_W-1:0]             reg_wdata,
    output logic [WORD_W-1:0]             reg_rdata,
    output logic [NUM_BANKS*WORD_W-1:0]   mod_clk_en,
    input  logic [NUM_BANKS*WORD_W-1:0]   mod_stop_ack
);
    localparam int NUM_MODS = NUM_BANKS * WORD_W;
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    acc_kind_e          acc_kind;
    logic [BANK_W-1:0]  acc_bank;
    logic [WORD_W-1:0]  ctrl_q [NUM_BANKS];
    logic [WORD_W-1:0]  stat_w [NUM_BANKS];
    logic [NUM_MODS-1:0] stat_flat;
    logic [NUM_BANKS-1:0] wr_hit;

    modstop_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .CTRL_BASE (CTRL_BASE),
        .STAT_BASE (STAT_BASE),
        .BANK_W    (BANK_W)
    ) u_decode (
        .addr (reg_addr),
        .kind (acc_kind),
        .bank (acc_bank)
    );

    modstop_status_sync #(
        .W      (NUM_MODS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_in   (mod_stop_ack),
        .status_q (stat_flat)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign wr_hit[b] = reg_we && (acc_kind == ACC_CTRL) && (acc_bank == BANK_W'(b));

        modstop_ctrl_word #(
            .W (WORD_W)
        ) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit[b]),
            .wr_data (reg_wdata),
            .word_q  (ctrl_q[b])
        );

        assign mod_clk_en[b*WORD_W +: WORD_W] = ~ctrl_q[b];
        assign stat_w[b] = stat_flat[b*WORD_W +: WORD_W];
    end

    // Select the read data from the addressed control or status word.
    always_comb begin
        case (acc_kind)
            ACC_CTRL: reg_rdata = ctrl_q[acc_bank];
            ACC_STAT: reg_rdata = stat_w[acc_bank];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/modstop_ctrl_chk.sv
// Checker for modstop_ctrl: port-level properties of the requirements.
// Attached to every instance of the top module by the bind below.
module modstop_ctrl_chk #(
    parameter int          NUM_BANKS   = 12,
    parameter int          ADDR_W      = 12,
    parameter int unsigned CTRL_BASE   = 'h130,
    parameter int unsigned STAT_BASE   = 'h030,
    parameter int          SYNC_STAGES = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [31:0]                 reg_wdata,
    input logic [31:0]                 reg_rdata,
    input logic [NUM_BANKS*32-1:0]     mod_clk_en,
    input logic [NUM_BANKS*32-1:0]     mod_stop_ack
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 1) + 1;
    localparam logic [ADDR_W:0] C_LO = (ADDR_W+1)'(CTRL_BASE);
    localparam logic [ADDR_W:0] C_HI = (ADDR_W+1)'(CTRL_BASE + 4 * NUM_BANKS);
    localparam logic [ADDR_W:0] S_LO = (ADDR_W+1)'(STAT_BASE);
    localparam logic [ADDR_W:0] S_HI = (ADDR_W+1)'(STAT_BASE + 4 * NUM_BANKS);

    logic [CNT_W-1:0] stable_cnt;
    logic [31:0]      last_ack;
    logic             mapped;

    // Count the cycles that bank 0's acknowledges have held still.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_cnt <= '0;
            last_ack   <= '1;
        end else begin
            last_ack <= mod_stop_ack[31:0];
            if (mod_stop_ack[31:0] != last_ack)
                stable_cnt <= '0;
            else if (stable_cnt < CNT_W'(SYNC_STAGES))
                stable_cnt <= stable_cnt + 1'b1;
        end
    end

    // Range form of the address map, independent of the decoder's match list.
    always_comb begin
        mapped = (reg_addr[1:0] == 2'b00) &&
                 ((({1'b0, reg_addr} >= C_LO) && ({1'b0, reg_addr} < C_HI)) ||
                  (({1'b0, reg_addr} >= S_LO) && ({1'b0, reg_addr} < S_HI)));
    end

    // R3: reset stops every module
    a_r3_reset_stops_all: assert property (@(posedge clk)
        !rst_n |=> (mod_clk_en == '0));

    // R5: status of bank 0 equals the acknowledges once they have settled
    a_r5_status_tracks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (stable_cnt >= CNT_W'(SYNC_STAGES) && reg_addr == ADDR_W'(STAT_BASE))
        |-> (reg_rdata == mod_stop_ack[31:0]));

    // R6: a write to a status word changes no enable
    a_r6_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(STAT_BASE)) |=> $stable(mod_clk_en));

    // R7: unmapped reads return zero
    a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (reg_rdata == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_prop
        // R2: a control write sets the inverse enables one cycle later
        a_r2_write_sets_enable: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == ADDR_W'(CTRL_BASE + 4 * b))
            |=> (mod_clk_en[b*32 +: 32] == ~$past(reg_wdata)));

        // R4: a write to any other address leaves this word's enables alone
        a_r4_other_banks_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_we && reg_addr == ADDR_W'(CTRL_BASE + 4 * b))
            |=> $stable(mod_clk_en[b*32 +: 32]));
    end
endmodule

bind modstop_ctrl modstop_ctrl_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .ADDR_W      (ADDR_W),
    .CTRL_BASE   (CTRL_BASE),
    .STAT_BASE   (STAT_BASE),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .mod_clk_en   (mod_clk_en),
    .mod_stop_ack (mod_stop_ack)
);

// File: tb/sim_modstop_ctrl.sv
// Bench for modstop_ctrl: directed corner cases plus seeded random traffic,
// compared with a word-level model built from the requirements.
module sim_modstop_ctrl;
    localparam int NB    = 12;
    localparam int AW    = 12;
    localparam int NM    = NB * 32;
    localparam int CB    = 'h130;
    localparam int SB    = 'h030;
    localparam int SYNC  = 2;
    localparam int ACK_D = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NM-1:0] mod_clk_en;
    logic [NM-1:0] mod_stop_ack;
    logic [NM-1:0] ack_pipe [ACK_D];

    logic [31:0] m_ctrl [NB];
    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    modstop_ctrl #(
        .NUM_BANKS (NB), .ADDR_W (AW), .CTRL_BASE (CB),
        .STAT_BASE (SB), .SYNC_STAGES (SYNC)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .mod_clk_en (mod_clk_en), .mod_stop_ack (mod_stop_ack)
    );

    // Module model: acknowledges a stop ACK_D cycles after the enable drops.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < ACK_D; s++) ack_pipe[s] <= '1;
        end else begin
            ack_pipe[0] <= ~mod_clk_en;
            for (int s = 1; s < ACK_D; s++) ack_pipe[s] <= ack_pipe[s-1];
        end
    end
    assign mod_stop_ack = ack_pipe[ACK_D-1];

    // Address class from R8 and R7: 0 none, 1 control, 2 status.
    function automatic int kind_of(input logic [AW-1:0] a);
        if (a[1:0] != 2'b00) return 0;
        if (int'(a) >= CB && int'(a) < CB + 4 * NB) return 1;
        if (int'(a) >= SB && int'(a) < SB + 4 * NB) return 2;
        return 0;
    endfunction

    function automatic int bank_of(input logic [AW-1:0] a);
        return (kind_of(a) == 1) ? (int'(a) - CB) / 4 : (int'(a) - SB) / 4;
    endfunction

    function automatic logic [NM-1:0] exp_en();
        logic [NM-1:0] v;
        for (int b = 0; b < NB; b++) v[b*32 +: 32] = ~m_ctrl[b];
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_en(input string req);
        total++;
        if (mod_clk_en !== exp_en()) begin
            fails++;
            $display("FAIL %s: actual enables %h expected %h", req, mod_clk_en, exp_en());
        end
    endtask

    // Write one word; returns just after the capturing edge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (kind_of(a) == 1) m_ctrl[bank_of(a)] = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int polls;
        for (int b = 0; b < NB; b++) m_ctrl[b] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state of enables, control and status
        @(negedge clk);
        check_en("R3 enables after reset");
        rd(12'(CB), d);            check("R3 control word 0 after reset", d, 32'hFFFF_FFFF);
        rd(12'(CB + 4 * 11), d);   check("R3 R8 last control word after reset", d, 32'hFFFF_FFFF);
        rd(12'(SB), d);            check("R3 status word 0 after reset", d, 32'hFFFF_FFFF);

        // R1 R2: release module 37 (word 1, bit 5) by read-modify-write
        rd(12'(CB + 4), d);
        wr(12'(CB + 4), d & ~(32'h1 << 5));
        check("R1 module 37 enable", 32'(mod_clk_en[37]), 32'd1);
        check("R1 R2 only one module enabled", $countones(mod_clk_en), 32'd1);

        // R5: status still reads stopped for exactly ACK_D+SYNC polls
        polls = 0;
        for (int i = 0; i < 1000; i++) begin
            reg_addr = 12'(SB + 4);
            #1;
            if (reg_rdata[5] == 1'b0) break;
            polls++;
            @(negedge clk);
        end
        check("R5 polls before status clears", 32'(polls), 32'(ACK_D + SYNC));
        check("R5 status word 1 once running", reg_rdata, 32'hFFFF_FFDF);

        // R2 R5: stop the module again
        wr(12'(CB + 4), 32'hFFFF_FFFF);
        check_en("R2 module 37 stopped again");
        repeat (8) @(negedge clk);
        rd(12'(SB + 4), d);        check("R5 status word 1 stopped again", d, 32'hFFFF_FFFF);

        // R4: one word written, all others intact
        wr(12'(CB + 12), 32'h5A5A_0F0F);
        for (int b = 0; b < NB; b++) begin
            rd(12'(CB + 4 * b), d);
            check("R4 control word readback", d, m_ctrl[b]);
        end
        check_en("R4 enables after single write");

        // R6: write to a status word is ignored
        wr(12'(SB + 8), 32'h0000_0000);
        check_en("R6 enables after status write");
        repeat (8) @(negedge clk);
        rd(12'(SB + 8), d);        check("R6 status unchanged", d, 32'hFFFF_FFFF);

        // R7: unmapped and misaligned accesses
        rd(12'h000, d);            check("R7 read 0x000", d, 32'h0);
        rd(12'(CB + 1), d);        check("R7 misaligned read", d, 32'h0);
        rd(12'(CB + 4 * NB), d);   check("R7 read past control range", d, 32'h0);
        rd(12'(SB + 4 * NB), d);   check("R7 read past status range", d, 32'h0);
        wr(12'(CB + 4 * NB), 32'h0);
        wr(12'(CB + 2), 32'h0);
        check_en("R7 unmapped writes ignored");

        // Random traffic over all address classes
        void'($urandom(32'h1d2c_3b4a));
        for (int n = 0; n < 400; n++) begin
            int sel = int'($urandom_range(0, 9));
            logic [AW-1:0] a;
            if (sel < 5)      a = 12'(CB + 4 * int'($urandom_range(0, NB - 1)));
            else if (sel < 7) a = 12'(SB + 4 * int'($urandom_range(0, NB - 1)));
            else              a = 12'($urandom_range(0, 4095));
            if ($urandom_range(0, 1) == 1) begin
                wr(a, $urandom());
                check_en("R2 R4 R6 R7 random write enables");
            end else begin
                if (kind_of(a) == 2) repeat (8) @(negedge clk);
                rd(a, d);
                case (kind_of(a))
                    1: check("R4 random control read", d, m_ctrl[bank_of(a)]);
                    2: check("R5 random status read", d, m_ctrl[bank_of(a)]);
                    default: check("R7 random unmapped read", d, 32'h0);
                endcase
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule